// File: doc/BRIEF.md
# CAN Bit Timing and Resynchronization Unit

This block derives the bit clock of a CAN node from the system clock. A programmable prescaler divides the clock into time quanta (TQ). Every bit time is built from four consecutive segments: a one-quantum synchronization segment, a propagation segment, a first phase segment and a second phase segment. At the end of the first phase segment the synchronized receive level is captured and presented with a one-clock strobe. At the start of every bit time a transmit-point strobe is raised, so that a transmitter can drive its next bit.

The receive line passes through a two-flop synchronizer. Recessive-to-dominant transitions (1 to 0) on the synchronized line keep the local bit clock aligned with the bus. While the idle/start-of-frame enable is high, such an edge restarts the bit time at once (hard synchronization). Otherwise the edge's phase error, counted in whole quanta, lengthens the first phase segment or shortens the second. That correction is capped by a programmable jump width. Frame decoding, arbitration, stuffing and error handling belong to neighbouring blocks.

Top module: `cbt_bit_clock`

## Requirements
- R1: One quantum lasts `brp_i+1` clock cycles. With no receive edges, `tx_stb_o` pulses once every N quanta, where N = 1 + (`prop_i`+1) + (`ph1_i`+1) + T2 and T2 is the second-phase length in quanta.
- R2: `sample_stb_o` is a one-cycle pulse that comes S = 1 + (`prop_i`+1) + (`ph1_i`+1) quanta after the bit start marked by `tx_stb_o`. With it, `sample_bit_o` shows the synchronized receive level. The two strobes never coincide.
- R3: The second phase length is `ph2_i`+1 quanta, but never less than 2: the code 0 gives 2 quanta.
- R4: When `sof_en_i` is high, a 1-to-0 transition of `rx_i` restarts the bit time. `tx_stb_o` pulses 3 cycles after the first clock edge that sees the low level, and the next sample follows S quanta later. The prescaler also restarts.
- R5: With `sof_en_i` low, an edge in the propagation or first phase segment that lies k quanta after the synchronization segment lengthens the first phase segment of that bit by min(k, J). The first propagation quantum has k = 1. J is the effective jump width.
- R6: With `sof_en_i` low, an edge in the second phase segment that has r quanta of that segment still to come after the current one shortens that segment by min(r, J). The next bit then starts earlier by the same amount.
- R7: An edge that falls inside the synchronization segment causes no correction.
- R8: The effective jump width J is `sjw_i`+1 quanta, reduced to the second phase length when it is larger.
- R9: After one synchronization (hard or corrective), later edges are ignored for correction until the next sample point.
- R10: With `sof_en_i` low, an edge never restarts the bit time. It is handled only by R5 to R7.
- R11: During reset all outputs are low. The first bit time starts when reset is released, so the first `tx_stb_o` comes N quanta after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_i | input | 1 | Asynchronous receive line, 1 = recessive |
| sof_en_i | input | 1 | High while the bus is idle; allows hard synchronization |
| brp_i | input | BRP_W | Prescaler code; quantum = brp_i+1 cycles |
| prop_i | input | SEG_W | Propagation segment code; length = prop_i+1 TQ |
| ph1_i | input | SEG_W | First phase segment code; length = ph1_i+1 TQ |
| ph2_i | input | SEG_W | Second phase segment code; length = max(ph2_i+1, 2) TQ |
| sjw_i | input | SJW_W | Jump width code; J = min(sjw_i+1, second phase length) |
| sample_stb_o | output | 1 | One-cycle strobe at the sample point |
| sample_bit_o | output | 1 | Receive level captured at the last sample point |
| tx_stb_o | output | 1 | One-cycle strobe at the start of each bit time |

## Verification
The hardest condition to reach is a resynchronizing edge that lands in one chosen quantum of one chosen segment while the one-per-bit budget is still unused. Free-running from reset gives an unknown phase, so each directed case first performs a hard synchronization that fixes the bit grid to a known cycle. It then drops `sof_en_i` and places a falling edge of `rx_i` exactly three cycles ahead of the target quantum, which covers the two synchronizer flops and the edge detector. Sweeping the quantum index through the synchronization, propagation, first-phase and second-phase regions reaches the uncapped, capped, ignored and early cases. A second edge inside the same window exercises the budget rule.

// File: rtl/cbt_pkg.sv
package cbt_pkg;

  // segments of one bit time, in the order they occur
  typedef enum logic [1:0] {
    SEG_SYNC = 2'd0,
    SEG_PROP = 2'd1,
    SEG_PH1  = 2'd2,
    SEG_PH2  = 2'd3
  } seg_e;

  // shortest allowed second phase: the processing time after sampling
  localparam int MIN_PH2_TQ = 2;

  function automatic seg_e seg_after(input seg_e s);
    case (s)
      SEG_SYNC: seg_after = SEG_PROP;
      SEG_PROP: seg_after = SEG_PH1;
      SEG_PH1:  seg_after = SEG_PH2;
      default:  seg_after = SEG_SYNC;
    endcase
  endfunction

endpackage

// File: rtl/cbt_quantum_gen.sv
// Prescaler: one tick per quantum, restartable on hard synchronization.
module cbt_quantum_gen #(
  parameter int BRP_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart_i,
  input  logic [BRP_W-1:0] brp_i,
  output logic             tick_o
);

  logic [BRP_W-1:0] cnt_q;
  logic             wrap;

  assign wrap   = (cnt_q >= brp_i);
  assign tick_o = wrap & ~restart_i;

  always_ff @(posedge clk) begin
    if (rst || restart_i) begin
      cnt_q <= '0;
    end else if (wrap) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/cbt_rx_sync.sv
// Synchronizer chain and recessive-to-dominant edge detector.
module cbt_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rx_i,
  output logic rx_s_o,
  output logic fall_o
);

  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '1;
        else     chain_q <= rx_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '1;
        else     chain_q <= {chain_q[STAGES-2:0], rx_i};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b1;
    else     prev_q <= chain_q[STAGES-1];
  end

  assign rx_s_o = chain_q[STAGES-1];
  assign fall_o = prev_q & ~chain_q[STAGES-1];

endmodule

// File: rtl/cbt_seg_ctrl.sv
// Segment sequencer with hard synchronization and phase correction.
module cbt_seg_ctrl
  import cbt_pkg::*;
#(
  parameter int LW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_i,
  input  logic          fall_i,
  input  logic          sof_en_i,
  input  logic [LW-1:0] prop_len_i,
  input  logic [LW-1:0] ph1_len_i,
  input  logic [LW-1:0] ph2_len_i,
  input  logic [LW-1:0] sjw_len_i,
  output logic          hsync_o,
  output logic          smp_pt_o,
  output logic          bit_end_o
);

  localparam logic [LW:0] ONE = (LW+1)'(1);

  seg_e          seg_q;
  logic [LW-1:0] qcnt_q;
  logic [LW-1:0] ext_q;
  logic [LW-1:0] trim_q;
  logic          synced_q;

  logic          resync, late, early, seg_last;
  logic [LW:0]   err;
  logic [LW-1:0] amt, ext_eff, trim_eff;

  always_comb begin
    hsync_o = fall_i & sof_en_i;
    resync  = fall_i & ~sof_en_i & ~synced_q;

    // phase error in whole quanta, measured from the synchronization segment
    case (seg_q)
      SEG_PROP: err = {1'b0, qcnt_q} + ONE;
      SEG_PH1:  err = {1'b0, prop_len_i} + {1'b0, qcnt_q} + ONE;
      SEG_PH2:  err = {1'b0, ph2_len_i} - {1'b0, qcnt_q} - ONE;
      default:  err = '0;
    endcase
    amt = (err > {1'b0, sjw_len_i}) ? sjw_len_i : err[LW-1:0];

    late  = resync & ((seg_q == SEG_PROP) | (seg_q == SEG_PH1));
    early = resync & (seg_q == SEG_PH2) & (err != '0);

    ext_eff  = late  ? amt : ext_q;
    trim_eff = early ? amt : trim_q;

    case (seg_q)
      SEG_SYNC: seg_last = 1'b1;
      SEG_PROP: seg_last = ({1'b0, qcnt_q} + ONE) >= {1'b0, prop_len_i};
      SEG_PH1:  seg_last = ({1'b0, qcnt_q} + ONE) >=
                           ({1'b0, ph1_len_i} + {1'b0, ext_eff});
      default:  seg_last = ({1'b0, qcnt_q} + ONE + {1'b0, trim_eff}) >=
                           {1'b0, ph2_len_i};
    endcase

    smp_pt_o  = tick_i & ~hsync_o & (seg_q == SEG_PH1) & seg_last;
    bit_end_o = tick_i & ~hsync_o & (seg_q == SEG_PH2) & seg_last;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seg_q    <= SEG_SYNC;
      qcnt_q   <= '0;
      ext_q    <= '0;
      trim_q   <= '0;
      synced_q <= 1'b0;
    end else if (hsync_o) begin
      seg_q    <= SEG_SYNC;
      qcnt_q   <= '0;
      ext_q    <= '0;
      trim_q   <= '0;
      synced_q <= 1'b1;
    end else begin
      if (late)         ext_q    <= amt;
      if (early)        trim_q   <= amt;
      if (late | early) synced_q <= 1'b1;
      if (tick_i) begin
        if (seg_last) begin
          seg_q  <= seg_after(seg_q);
          qcnt_q <= '0;
          if (seg_q == SEG_PH1) synced_q <= 1'b0;
          if (seg_q == SEG_PH2) begin
            ext_q  <= '0;
            trim_q <= '0;
          end
        end else begin
          qcnt_q <= qcnt_q + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/cbt_bit_clock.sv
// Top: setting decode, prescaler, synchronizer, sequencer, registered strobes.
module cbt_bit_clock
  import cbt_pkg::*;
#(
  parameter int BRP_W       = 6,
  parameter int SEG_W       = 3,
  parameter int SJW_W       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_i,
  input  logic             sof_en_i,
  input  logic [BRP_W-1:0] brp_i,
  input  logic [SEG_W-1:0] prop_i,
  input  logic [SEG_W-1:0] ph1_i,
  input  logic [SEG_W-1:0] ph2_i,
  input  logic [SJW_W-1:0] sjw_i,
  output logic             sample_stb_o,
  output logic             sample_bit_o,
  output logic             tx_stb_o
);

  localparam int LW = SEG_W + 1;
  localparam logic [LW-1:0] PH2_FLOOR = LW'(MIN_PH2_TQ);

  logic [LW-1:0] prop_len, ph1_len, ph2_len, ph2_raw, sjw_raw, sjw_len;
  logic          q_tick, rx_s, rx_fall, hsync, smp_pt, bit_end;

  always_comb begin
    prop_len = LW'(prop_i) + 1'b1;
    ph1_len  = LW'(ph1_i) + 1'b1;
    ph2_raw  = LW'(ph2_i) + 1'b1;
    ph2_len  = (ph2_raw < PH2_FLOOR) ? PH2_FLOOR : ph2_raw;
    sjw_raw  = LW'(sjw_i) + 1'b1;
    sjw_len  = (sjw_raw > ph2_len) ? ph2_len : sjw_raw;
  end

  cbt_quantum_gen #(.BRP_W(BRP_W)) u_qgen (
    .clk       (clk),
    .rst       (rst),
    .restart_i (hsync),
    .brp_i     (brp_i),
    .tick_o    (q_tick)
  );

  cbt_rx_sync #(.STAGES(SYNC_STAGES)) u_rxs (
    .clk    (clk),
    .rst    (rst),
    .rx_i   (rx_i),
    .rx_s_o (rx_s),
    .fall_o (rx_fall)
  );

  cbt_seg_ctrl #(.LW(LW)) u_seg (
    .clk        (clk),
    .rst        (rst),
    .tick_i     (q_tick),
    .fall_i     (rx_fall),
    .sof_en_i   (sof_en_i),
    .prop_len_i (prop_len),
    .ph1_len_i  (ph1_len),
    .ph2_len_i  (ph2_len),
    .sjw_len_i  (sjw_len),
    .hsync_o    (hsync),
    .smp_pt_o   (smp_pt),
    .bit_end_o  (bit_end)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sample_stb_o <= 1'b0;
      sample_bit_o <= 1'b0;
      tx_stb_o     <= 1'b0;
    end else begin
      sample_stb_o <= smp_pt;
      tx_stb_o     <= bit_end | hsync;
      if (smp_pt) sample_bit_o <= rx_s;
    end
  end

endmodule

// File: rtl/cbt_bit_clock_chk.sv
module cbt_bit_clock_chk #(
  parameter int BRP_W = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             sof_en_i,
  input logic [BRP_W-1:0] brp_i,
  input logic             tick,
  input logic             rx_fall,
  input logic             sample_stb_o,
  input logic             tx_stb_o
);

  logic [BRP_W-1:0] gap_q;
  logic             bit_open_q;

  // cycles since the last quantum boundary or restart
  always_ff @(posedge clk) begin
    if (rst || tick || (rx_fall && sof_en_i)) gap_q <= '0;
    else                                      gap_q <= gap_q + 1'b1;
  end

  // a bit has started and not yet been sampled
  always_ff @(posedge clk) begin
    if (rst)               bit_open_q <= 1'b1;
    else if (tx_stb_o)     bit_open_q <= 1'b1;
    else if (sample_stb_o) bit_open_q <= 1'b0;
  end

  assert_tick_spacing_R1: assert property (@(posedge clk) disable iff (rst)
    tick |-> (gap_q == brp_i));

  assert_stb_exclusive_R2: assert property (@(posedge clk) disable iff (rst)
    !(sample_stb_o && tx_stb_o));

  assert_sample_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    sample_stb_o |=> !sample_stb_o);

  assert_sample_in_bit_R2: assert property (@(posedge clk) disable iff (rst)
    sample_stb_o |-> bit_open_q);

  assert_hsync_restart_R4: assert property (@(posedge clk) disable iff (rst)
    (rx_fall && sof_en_i) |=> (tx_stb_o && !sample_stb_o));

endmodule

bind cbt_bit_clock cbt_bit_clock_chk #(.BRP_W(BRP_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .sof_en_i     (sof_en_i),
  .brp_i        (brp_i),
  .tick         (q_tick),
  .rx_fall      (rx_fall),
  .sample_stb_o (sample_stb_o),
  .tx_stb_o     (tx_stb_o)
);

// File: tb/cbt_bit_clock_bench.sv
module cbt_bit_clock_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx = 1'b1;
  logic       sof_en = 1'b0;
  logic [5:0] brp = 6'd0;
  logic [2:0] prop = 3'd0, ph1 = 3'd0, ph2 = 3'd0;
  logic [1:0] sjw = 2'd0;
  logic       smp_stb, smp_bit, tx_stb;

  cbt_bit_clock u_cbt_bit_clock (
    .clk (clk), .rst (rst), .rx_i (rx), .sof_en_i (sof_en),
    .brp_i (brp), .prop_i (prop), .ph1_i (ph1), .ph2_i (ph2), .sjw_i (sjw),
    .sample_stb_o (smp_stb), .sample_bit_o (smp_bit), .tx_stb_o (tx_stb)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int  checks = 0, fails = 0;
  bit  done = 1'b0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_stb(input bit want_tx, output int at);
    at = -1;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (want_tx ? tx_stb : smp_stb) begin
        at = cyc;
        break;
      end
    end
  endtask

  task automatic do_reset(output int rel);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    rel = cyc;
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  // falling edge seen by the sequencer at the posedge that makes cyc == x
  task automatic fall_at(input int x);
    wait_until(x - 3);
    rx = 1'b0;
    repeat (2) @(negedge clk);
    rx = 1'b1;
  endtask

  // B = 4 cycles per quantum; returns the cycle the hard-synced bit starts
  task automatic setup_dir(input int p, input int t1, input int t2c, input int sj,
                           output int h);
    int rel, t, s, sp;
    brp = 6'd3; prop = 3'(p - 1); ph1 = 3'(t1 - 1); ph2 = 3'(t2c); sjw = 2'(sj);
    sof_en = 1'b1; rx = 1'b1;
    do_reset(rel);
    repeat (5) @(negedge clk);
    sp = 1 + p + t1;
    h = cyc + 3;
    rx = 1'b0;
    wait_stb(1'b1, t);
    chk("R4 tx strobe after hard sync", t, h);
    wait_stb(1'b0, s);
    chk("R4 sample after hard sync", s, h + sp * 4);
    chk("R2 sampled level low", int'(smp_bit), 0);
    rx = 1'b1;
    sof_en = 1'b0;
  endtask

  task automatic late_case(input string tag, input int j, input int ext);
    int h, s;
    setup_dir(2, 3, 3, 1, h);             // S = 6, N = 10, J = 2
    fall_at(h + (10 + j) * 4 + 1);
    wait_stb(1'b0, s);
    chk(tag, s, h + (10 + 6 + ext) * 4);
  endtask

  task automatic early_case(input string tag, input int j, input int trim);
    int h, s, t;
    setup_dir(2, 3, 3, 1, h);
    fall_at(h + (10 + j) * 4 + 1);
    wait_stb(1'b1, t);
    chk({tag, " bit start"}, t, h + (20 - trim) * 4);
    wait_stb(1'b0, s);
    chk({tag, " next sample"}, s, h + (20 - trim + 6) * 4);
  endtask

  initial begin
    int rel, t0, t1, s1, s2, h, s;
    int brps[2]  = '{0, 2};
    int props[3] = '{0, 2, 7};
    int ph1s[3]  = '{0, 3, 7};

    // R11: reset state
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R11 sample strobe in reset", int'(smp_stb), 0);
    chk("R11 tx strobe in reset", int'(tx_stb), 0);
    chk("R11 sample bit in reset", int'(smp_bit), 0);

    // sweep of nominal timing, no receive edges
    for (int a = 0; a < 2; a++)
      for (int b = 0; b < 3; b++)
        for (int c = 0; c < 3; c++)
          for (int d = 0; d < 8; d++) begin
            int bq, sp, np, t2;
            brp = 6'(brps[a]); prop = 3'(props[b]); ph1 = 3'(ph1s[c]);
            ph2 = 3'(d); sjw = 2'd0; sof_en = 1'b0; rx = 1'b1;
            bq = brps[a] + 1;
            t2 = (d == 0) ? 2 : d + 1;
            sp = 1 + props[b] + 1 + ph1s[c] + 1;
            np = sp + t2;
            do_reset(rel);
            wait_stb(1'b1, t0);
            chk("R11 first bit start after release", t0, rel + np * bq);
            wait_stb(1'b0, s1);
            chk("R2 sample offset", s1, t0 + sp * bq);
            chk("R2 sampled level high", int'(smp_bit), 1);
            wait_stb(1'b1, t1);
            chk((d == 0) ? "R3 clamped bit period" : "R1 bit period",
                t1, t0 + np * bq);
            wait_stb(1'b0, s2);
            chk("R2 sample offset second bit", s2, t1 + sp * bq);
          end

    // edge inside the synchronization segment: no correction
    late_case("R7 edge in sync segment", 0, 0);
    // late edges
    late_case("R5 late edge one quantum", 1, 1);
    late_case("R5 late edge capped by jump width", 5, 2);
    late_case("R10 no restart with enable low", 2, 2);
    // early edges
    early_case("R6 early edge within jump width", 8, 1);
    early_case("R6 early edge capped by jump width", 6, 2);

    // R9: second edge in the same window ignored
    setup_dir(2, 3, 3, 3, h);               // J = 4
    fall_at(h + (10 + 1) * 4 + 1);
    fall_at(h + (10 + 4) * 4 + 1);
    wait_stb(1'b0, s);
    chk("R9 only first edge corrects", s, h + (10 + 6 + 1) * 4);

    // R8: jump width limited to second phase (2 TQ) although code asks 4
    setup_dir(2, 3, 1, 3, h);               // S = 6, N = 8
    fall_at(h + (8 + 4) * 4 + 1);
    wait_stb(1'b0, s);
    chk("R8 jump width clamped to phase 2", s, h + (8 + 6 + 2) * 4);

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule